// File: doc/BRIEF.md
# Indexed Register Window for an Interrupt Router

This block is the slave-side access path to an interrupt router's configuration space. It uses two address offsets. A bus master first writes a register number into the selector register. It then reads or writes a 32-bit data window, and the access goes to the register that the selector names. The selector can name a small identity register, a fixed version word, an arbitration word, or either half of a 64-bit routing entry. The routing entries themselves live in the delivery engine, which sits next to this block.

On every accepted window write to a routing-entry half, the block builds the complete new 64-bit entry value. The half that was written comes from the bus data and the other half comes from the entry's current contents. The block presents the entry number and this value to the delivery engine with a one-cycle strobe, and the engine uses that strobe to start a service pass. The entry named by the selector is always shown to the engine on a read-index output, and the engine returns that entry's contents combinationally.

Top module: `irw_window`

## Requirements
- R1: After reset the selector and the stored identity field are 0, `rsp_rdata` is 0 and `ent_wr_strobe` is low.
- R2: Offset 0x00 is the selector register. It is 8 bits wide and accepts reads and writes of any size. A write stores `req_wdata[7:0]`. A read returns the selector zero-extended to 32 bits.
- R3: A read of any `req_off` other than 0x00 or 0x10 returns 0. A write to such an offset changes no state and raises no strobe.
- R4: A window access (offset 0x10) whose `req_size` is not 4 bytes has no effect. A read returns 0, and a write changes nothing and raises no strobe.
- R5: Selector 0x00 names the identity register. A full window write stores `req_wdata[27:24]`. Reads at selector 0x00 and at selector 0x02 (arbitration) both return the stored identity in bits 27:24, with all other bits 0.
- R6: A read at selector 0x01 returns 0x00170011, which is version code 0x11 ORed with (24 − 1) in bits 23:16. Window writes at selectors 0x01 and 0x02 are ignored.
- R7: For a selector of 0x10 or more, the entry number is (selector − 0x10) >> 1. An odd selector maps to bits 63:32 of that entry and an even selector maps to bits 31:0. A read returns that half of `ent_rd_data`, and `ent_rd_index` carries the entry number.
- R8: A full window write to an entry half drives `ent_wr_strobe` high for exactly one cycle. While it is high, `ent_wr_index` holds the entry number and `ent_wr_value` holds the new 64-bit entry, in which the half that was not written equals its value before the write.
- R9: A selector from 0x03 to 0x0F, or any selector at which the entry number would be 24 or more (0x40 and above), reads as 0. A write at such a selector raises no strobe.
- R10: Every full window write to an in-range entry half raises the strobe, even when the value written matches the current contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 8 | Decoded low address byte |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, updated after each read request |
| ent_wr_strobe | output | 1 | One-cycle routing-entry update strobe |
| ent_wr_index | output | 5 | Entry number that is being updated |
| ent_wr_value | output | 64 | Full new entry value |
| ent_rd_index | output | 5 | Entry named by the current selector |
| ent_rd_data | input | 64 | Contents of entry `ent_rd_index`, returned by the delivery engine |

## Verification
Every result is registered once. A request sampled at one rising edge therefore shows its read data, selector update, identity update or entry strobe right after that edge, and the strobe drops again after the next edge. The bench drives each request on a falling edge and samples on the following falling edge. It then holds one idle cycle, in which it checks that the strobe has fallen and in which its model of the delivery engine absorbs the update, so every later readback sees committed entry contents.

// File: rtl/irw_pkg.sv
package irw_pkg;

    // What the current selector value points at inside the window
    typedef enum logic [2:0] {
        WK_ID    = 3'd0,
        WK_VER   = 3'd1,
        WK_ARB   = 3'd2,
        WK_ENTRY = 3'd3,
        WK_NONE  = 3'd4
    } win_kind_e;

    // Which bus offset a request hits
    typedef enum logic [1:0] {
        HIT_SEL  = 2'd0,
        HIT_WIN  = 2'd1,
        HIT_NONE = 2'd2
    } off_hit_e;

endpackage

// File: rtl/irw_win_decode.sv
module irw_win_decode
    import irw_pkg::*;
#(
    parameter int          IDX_W      = 8,
    parameter int          NUM_PINS   = 24,
    parameter int          ENT_W      = 5,
    parameter logic [7:0]  SEL_ID     = 8'h00,
    parameter logic [7:0]  SEL_VER    = 8'h01,
    parameter logic [7:0]  SEL_ARB    = 8'h02,
    parameter logic [7:0]  ENTRY_BASE = 8'h10
) (
    input  logic [IDX_W-1:0] sel,
    output win_kind_e        kind,
    output logic [ENT_W-1:0] ent_num,
    output logic             hi_half
);
    // One extra bit catches selectors below the entry base
    logic [IDX_W:0]   rel;
    logic [IDX_W-1:0] ent_full;
    logic             below_base;

    always_comb begin
        rel        = {1'b0, sel} - {1'b0, IDX_W'(ENTRY_BASE)};
        below_base = rel[IDX_W];
        ent_full   = rel[IDX_W:1];
        hi_half    = rel[0];
        ent_num    = '0;
        if (sel == IDX_W'(SEL_ID)) begin
            kind = WK_ID;
        end else if (sel == IDX_W'(SEL_VER)) begin
            kind = WK_VER;
        end else if (sel == IDX_W'(SEL_ARB)) begin
            kind = WK_ARB;
        end else if (!below_base && (ent_full < IDX_W'(NUM_PINS))) begin
            kind    = WK_ENTRY;
            ent_num = ent_full[ENT_W-1:0];
        end else begin
            kind = WK_NONE;
        end
    end

endmodule

// File: rtl/irw_half_merge.sv
module irw_half_merge #(
    parameter int WORD_W = 32,
    parameter int HALVES = 2
) (
    input  logic [WORD_W*HALVES-1:0] cur_entry,
    input  logic [WORD_W-1:0]        new_word,
    input  logic                     hi_sel,
    output logic [WORD_W*HALVES-1:0] merged
);
    // Each half takes the bus word only when it is the selected one
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign merged[h*WORD_W +: WORD_W] =
            (int'(hi_sel) == h) ? new_word : cur_entry[h*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/irw_read_mux.sv
module irw_read_mux
    import irw_pkg::*;
#(
    parameter int          ID_W      = 4,
    parameter int          ID_LSB    = 24,
    parameter logic [31:0] VER_VALUE = 32'h0017_0011
) (
    input  win_kind_e       kind,
    input  logic            hi_half,
    input  logic [63:0]     entry,
    input  logic [ID_W-1:0] id,
    output logic [31:0]     word
);
    always_comb begin
        unique case (kind)
            WK_ID, WK_ARB: word = 32'(id) << ID_LSB;
            WK_VER:        word = VER_VALUE;
            WK_ENTRY:      word = hi_half ? entry[63:32] : entry[31:0];
            default:       word = '0;
        endcase
    end

endmodule

// File: rtl/irw_window.sv
module irw_window
    import irw_pkg::*;
#(
    parameter int         NUM_PINS   = 24,
    parameter int         IDX_W      = 8,
    parameter int         ID_W       = 4,
    parameter int         ID_LSB     = 24,
    parameter logic [7:0] VER_CODE   = 8'h11,
    parameter int         MAXENT_LSB = 16,
    parameter logic [7:0] OFF_SEL    = 8'h00,
    parameter logic [7:0] OFF_WIN    = 8'h10,
    parameter logic [7:0] ENTRY_BASE = 8'h10,
    parameter int         FULL_BYTES = 4,
    localparam int        ENT_W      = $clog2(NUM_PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [7:0]       req_off,
    input  logic [2:0]       req_size,
    input  logic [31:0]      req_wdata,
    output logic [31:0]      rsp_rdata,
    output logic             ent_wr_strobe,
    output logic [ENT_W-1:0] ent_wr_index,
    output logic [63:0]      ent_wr_value,
    output logic [ENT_W-1:0] ent_rd_index,
    input  logic [63:0]      ent_rd_data
);
    localparam logic [31:0] VER_VALUE =
        32'(VER_CODE) | (32'(NUM_PINS - 1) << MAXENT_LSB);

    typedef struct packed {
        logic [IDX_W-1:0] sel;
        logic [ID_W-1:0]  id;
        logic [31:0]      rdata;
        logic             stb;
        logic [ENT_W-1:0] stb_idx;
        logic [63:0]      stb_val;
    } state_t;

    state_t st_d, st_q;

    win_kind_e        kind_w;
    logic [ENT_W-1:0] ent_num_w;
    logic             hi_w;
    logic [63:0]      merged_w;
    logic [31:0]      win_word_w;
    off_hit_e         hit_w;
    logic             full_w;

    irw_win_decode #(
        .IDX_W(IDX_W), .NUM_PINS(NUM_PINS), .ENT_W(ENT_W),
        .SEL_ID(8'h00), .SEL_VER(8'h01), .SEL_ARB(8'h02),
        .ENTRY_BASE(ENTRY_BASE)
    ) u_decode (
        .sel(st_q.sel), .kind(kind_w), .ent_num(ent_num_w), .hi_half(hi_w)
    );

    irw_half_merge #(.WORD_W(32), .HALVES(2)) u_merge (
        .cur_entry(ent_rd_data), .new_word(req_wdata),
        .hi_sel(hi_w), .merged(merged_w)
    );

    irw_read_mux #(.ID_W(ID_W), .ID_LSB(ID_LSB), .VER_VALUE(VER_VALUE)) u_rmux (
        .kind(kind_w), .hi_half(hi_w), .entry(ent_rd_data),
        .id(st_q.id), .word(win_word_w)
    );

    always_comb begin
        if (req_off == OFF_SEL)      hit_w = HIT_SEL;
        else if (req_off == OFF_WIN) hit_w = HIT_WIN;
        else                         hit_w = HIT_NONE;
        full_w = (req_size == 3'(FULL_BYTES));
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (req_valid) begin
            unique case (hit_w)
                HIT_SEL: begin
                    if (req_write) st_d.sel   = req_wdata[IDX_W-1:0];
                    else           st_d.rdata = 32'(st_q.sel);
                end
                HIT_WIN: begin
                    if (!full_w) begin
                        if (!req_write) st_d.rdata = '0;
                    end else if (!req_write) begin
                        st_d.rdata = win_word_w;
                    end else begin
                        unique case (kind_w)
                            WK_ID: st_d.id = req_wdata[ID_LSB +: ID_W];
                            WK_ENTRY: begin
                                st_d.stb     = 1'b1;
                                st_d.stb_idx = ent_num_w;
                                st_d.stb_val = merged_w;
                            end
                            default: ;
                        endcase
                    end
                end
                default: begin
                    if (!req_write) st_d.rdata = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_rdata     = st_q.rdata;
    assign ent_wr_strobe = st_q.stb;
    assign ent_wr_index  = st_q.stb_idx;
    assign ent_wr_value  = st_q.stb_val;
    assign ent_rd_index  = ent_num_w;

    // ---------------- assertions ----------------
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ent_wr_strobe && rsp_rdata == 32'd0));

    assert_unmapped_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_off != OFF_SEL && req_off != OFF_WIN)
        |=> (rsp_rdata == 32'd0));

    assert_short_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_off == OFF_WIN && req_size != 3'(FULL_BYTES))
        |=> (rsp_rdata == 32'd0));

    assert_short_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size != 3'(FULL_BYTES)) |=> !ent_wr_strobe);

    assert_id_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_off == OFF_WIN && req_size == 3'(FULL_BYTES)
          && kind_w == WK_ID) |=> $stable(st_q.id));

    assert_version_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_off == OFF_WIN && req_size == 3'(FULL_BYTES)
         && kind_w == WK_VER) |=> (rsp_rdata == VER_VALUE));

    assert_keep_low_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_off == OFF_WIN && req_size == 3'(FULL_BYTES)
         && kind_w == WK_ENTRY && hi_w)
        |=> (ent_wr_strobe && ent_wr_value[31:0] == $past(ent_rd_data[31:0])));

    assert_keep_high_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_off == OFF_WIN && req_size == 3'(FULL_BYTES)
         && kind_w == WK_ENTRY && !hi_w)
        |=> (ent_wr_strobe && ent_wr_value[63:32] == $past(ent_rd_data[63:32])));

    assert_strobe_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr_strobe |-> (ent_wr_index < ENT_W'(NUM_PINS)));

    assert_strobe_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr_strobe |-> $past(req_valid && req_write && req_off == OFF_WIN));

endmodule

// File: tb/irw_window_bench.sv
module irw_window_bench;

    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        ent_wr_strobe;
    logic [4:0]  ent_wr_index;
    logic [63:0] ent_wr_value;
    logic [4:0]  ent_rd_index;
    logic [63:0] ent_rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    irw_window u_irw_window (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .ent_wr_strobe(ent_wr_strobe),
        .ent_wr_index(ent_wr_index), .ent_wr_value(ent_wr_value),
        .ent_rd_index(ent_rd_index), .ent_rd_data(ent_rd_data)
    );

    // Delivery-engine model: entry i starts as {B000_0000+i, C000_0000+i}
    logic [63:0] ent_mem [NP];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++)
                ent_mem[i] <= {32'hB000_0000 + 32'(i), 32'hC000_0000 + 32'(i)};
        end else if (ent_wr_strobe && int'(ent_wr_index) < NP) begin
            ent_mem[ent_wr_index] <= ent_wr_value;
        end
    end
    assign ent_rd_data = (int'(ent_rd_index) < NP) ? ent_mem[ent_rd_index] : 64'd0;

    typedef struct packed {
        logic        wr;
        logic [7:0]  off;
        logic [2:0]  size;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        logic        exp_stb;
        logic [4:0]  exp_idx;
        logic [63:0] exp_val;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 3'd1, 32'h05,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},  // R2 byte write
        '{1'b0, 8'h00, 3'd4, 32'h0,         32'h05,       1'b0, 5'd0,  64'h0, 4'd2},  // R2
        '{1'b0, 8'h00, 3'd1, 32'h0,         32'h05,       1'b0, 5'd0,  64'h0, 4'd2},  // R2 any size
        '{1'b1, 8'h00, 3'd4, 32'h00,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},
        '{1'b1, 8'h10, 3'd4, 32'h0A00_0000, 32'h0,        1'b0, 5'd0,  64'h0, 4'd5},  // R5 id write
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'h0A00_0000,1'b0, 5'd0,  64'h0, 4'd5},  // R5
        '{1'b1, 8'h00, 3'd4, 32'h02,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'h0A00_0000,1'b0, 5'd0,  64'h0, 4'd5},  // R5 arb read
        '{1'b1, 8'h10, 3'd4, 32'h0500_0000, 32'h0,        1'b0, 5'd0,  64'h0, 4'd6},  // R6 arb write
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'h0A00_0000,1'b0, 5'd0,  64'h0, 4'd6},  // R6
        '{1'b1, 8'h00, 3'd4, 32'h01,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'h0017_0011,1'b0, 5'd0,  64'h0, 4'd6},  // R6 version
        '{1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF, 32'h0,        1'b0, 5'd0,  64'h0, 4'd6},  // R6
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'h0017_0011,1'b0, 5'd0,  64'h0, 4'd6},  // R6
        '{1'b1, 8'h00, 3'd4, 32'h14,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'hC000_0002,1'b0, 5'd0,  64'h0, 4'd7},  // R7 low half
        '{1'b1, 8'h10, 3'd4, 32'h1234_5678, 32'h0,        1'b1, 5'd2,  64'hB000_0002_1234_5678, 4'd8}, // R8
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'h1234_5678,1'b0, 5'd0,  64'h0, 4'd7},  // R7
        '{1'b1, 8'h00, 3'd4, 32'h3F,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'hB000_0017,1'b0, 5'd0,  64'h0, 4'd7},  // R7 last high
        '{1'b1, 8'h10, 3'd4, 32'hDEAD_BEEF, 32'h0,        1'b1, 5'd23, 64'hDEAD_BEEF_C000_0017, 4'd8}, // R8
        '{1'b1, 8'h10, 3'd4, 32'hDEAD_BEEF, 32'h0,        1'b1, 5'd23, 64'hDEAD_BEEF_C000_0017, 4'd10},// R10
        '{1'b1, 8'h00, 3'd4, 32'h40,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'h0,        1'b0, 5'd0,  64'h0, 4'd9},  // R9 above
        '{1'b1, 8'h10, 3'd4, 32'h1111_1111, 32'h0,        1'b0, 5'd0,  64'h0, 4'd9},  // R9
        '{1'b1, 8'h00, 3'd4, 32'h07,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'h0,        1'b0, 5'd0,  64'h0, 4'd9},  // R9 gap
        '{1'b1, 8'h10, 3'd4, 32'h2222_2222, 32'h0,        1'b0, 5'd0,  64'h0, 4'd9},  // R9
        '{1'b1, 8'h00, 3'd4, 32'h15,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},
        '{1'b0, 8'h10, 3'd2, 32'h0,         32'h0,        1'b0, 5'd0,  64'h0, 4'd4},  // R4 short read
        '{1'b1, 8'h10, 3'd2, 32'h3333_3333, 32'h0,        1'b0, 5'd0,  64'h0, 4'd4},  // R4 short write
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'hB000_0002,1'b0, 5'd0,  64'h0, 4'd4},  // R4 unchanged
        '{1'b0, 8'h08, 3'd4, 32'h0,         32'h0,        1'b0, 5'd0,  64'h0, 4'd3},  // R3
        '{1'b1, 8'h08, 3'd4, 32'h99,        32'h0,        1'b0, 5'd0,  64'h0, 4'd3},  // R3
        '{1'b0, 8'h00, 3'd4, 32'h0,         32'h15,       1'b0, 5'd0,  64'h0, 4'd3},  // R3 selector kept
        '{1'b0, 8'hFF, 3'd4, 32'h0,         32'h0,        1'b0, 5'd0,  64'h0, 4'd3},  // R3
        '{1'b1, 8'h00, 3'd1, 32'h16,        32'h0,        1'b0, 5'd0,  64'h0, 4'd2},
        '{1'b0, 8'h10, 3'd4, 32'h0,         32'hC000_0003,1'b0, 5'd0,  64'h0, 4'd7}   // R7
    };

    task automatic check(input bit ok, input int rq, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Drive on a falling edge, sample one edge later, then one idle cycle
    task automatic access(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_off = v.off;
        req_size = v.size; req_wdata = v.wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (!v.wr) begin
            check(rsp_rdata == v.exp_rd && !ent_wr_strobe, int'(v.rq),
                  {31'd0, ent_wr_strobe, rsp_rdata}, {32'd0, v.exp_rd});
        end else if (v.exp_stb) begin
            check(ent_wr_strobe && ent_wr_index == v.exp_idx && ent_wr_value == v.exp_val,
                  int'(v.rq), ent_wr_value, v.exp_val);
        end else begin
            check(!ent_wr_strobe, int'(v.rq), {63'd0, ent_wr_strobe}, 64'd0);
        end
        @(negedge clk);
        // R8: strobe lasts a single cycle
        if (v.wr && v.exp_stb)
            check(!ent_wr_strobe, 8, {63'd0, ent_wr_strobe}, 64'd0);
    endtask

    function automatic vec_t mk(input logic wr, input logic [7:0] off,
                                input logic [31:0] wd, input logic [31:0] rd);
        mk = '{wr, off, 3'd4, wd, rd, 1'b0, 5'd0, 64'd0, 4'd1};
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs quiet during and right after reset
        check(rsp_rdata == 0 && !ent_wr_strobe, 1, {31'd0, ent_wr_strobe, rsp_rdata}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_rdata == 0 && !ent_wr_strobe, 1, {31'd0, ent_wr_strobe, rsp_rdata}, 64'd0);

        for (int k = 0; k < NV; k++) access(VECS[k]);

        // R1: reset mid-run clears selector and identity
        access(mk(1'b1, 8'h00, 32'h00, 32'h0));
        access(mk(1'b1, 8'h10, 32'h0F00_0000, 32'h0));
        access(mk(1'b1, 8'h00, 32'h3A, 32'h0));
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(rsp_rdata == 0 && !ent_wr_strobe, 1, {32'd0, rsp_rdata}, 64'd0);
        rst_n = 1'b1;
        access(mk(1'b0, 8'h00, 32'h0, 32'h0));   // R1 selector back to 0
        access(mk(1'b0, 8'h10, 32'h0, 32'h0));   // R1 identity back to 0

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule